// File: doc/BRIEF.md
# Hypervector Class Prototype Trainer

This block keeps one integer accumulator per dimension for every class of a hypervector classifier and turns them into binary class prototypes on demand. An upstream encoder presents a binary sample hypervector with a command. In plain training the sample is folded into the accumulator row of its labelled class. When an earlier search picked the wrong class, a corrective command folds the sample into the right class and takes it back out of the wrongly chosen one in the same pass. No gradients are involved.

A sample bit of 1 counts as +1 and a bit of 0 counts as −1. The accumulators are signed and clamp at their limits. Each command walks the accumulator rows a fixed number of dimensions per clock, so its cost grows with the vector length. A separate command thresholds every accumulator into a stored binary prototype. A similarity search engine reads that prototype through a combinational class-select port, and it changes only when that command runs.

Top module: `hdc_proto_trainer`

## Requirements
- R1: During and after reset, `busy` and `done` are 0 and every stored prototype reads as all zeros.
- R2: A train command (`cmd_op` = 2'b00) with `true_label` < NUM_CLASSES adds +1 to accumulator d of that class where bit d of `sample_hv` is 1 and −1 where it is 0. Every other class is left unchanged.
- R3: A retrain command (`cmd_op` = 2'b01) with two different in-range labels applies the R2 update to `true_label` and the opposite update (−1 for a 1 bit, +1 for a 0 bit) to `pred_label`.
- R4: A retrain command whose two labels are equal is not accepted: `busy` stays 0 and no accumulator changes.
- R5: Each accumulator is ACC_W bits in two's complement. It clamps at 2^(ACC_W−1)−1 and at −2^(ACC_W−1) and never wraps.
- R6: A binarize command (`cmd_op` = 2'b10) sets bit d of each class prototype to 1 when accumulator d is greater than zero and to 0 otherwise, including when it is zero.
- R7: Train and retrain commands leave `rd_proto` unchanged. Prototypes follow the accumulators only through a binarize command.
- R8: An accepted command raises `busy` in the cycle after acceptance and holds it for exactly DIM/LANES cycles. `done` pulses for one cycle as `busy` falls. A command offered while `busy` is 1 is ignored.
- R9: A train or retrain command with a label ≥ NUM_CLASSES, and any command with `cmd_op` = 2'b11, is not accepted and changes nothing.
- R10: `rd_proto` shows the prototype of class `rd_class`, bit d being dimension d. A `rd_class` ≥ NUM_CLASSES reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 train, 01 retrain, 10 binarize, 11 none |
| sample_hv | input | DIM | Encoded binary sample, bit d is dimension d |
| true_label | input | $clog2(NUM_CLASSES) | Correct class of the sample |
| pred_label | input | $clog2(NUM_CLASSES) | Class that was wrongly predicted (retrain only) |
| busy | output | 1 | A command is being processed |
| done | output | 1 | One-cycle pulse as a command finishes |
| rd_class | input | $clog2(NUM_CLASSES) | Class whose prototype is read |
| rd_proto | output | DIM | Binary prototype of `rd_class` |

## Verification
The bench builds the block with three classes, 32 dimensions, 8 lanes and 4-bit accumulators. With three classes, label value 3 fits in the label field but is out of range, so the rejection path gets exercised. With 4-bit accumulators, a dozen repeated samples drive values into both clamps. The positive clamp is then backed off by a known count, so a design that wraps gives visibly different prototype bits. Four beats per command keep each busy window short enough to test a command offered mid-update.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  typedef enum logic [1:0] {
    OP_TRAIN    = 2'b00,
    OP_RETRAIN  = 2'b01,
    OP_BINARIZE = 2'b10,
    OP_NONE     = 2'b11
  } hdc_op_e;

endpackage

// File: rtl/hdc_ctrl.sv
module hdc_ctrl
  import hdc_pkg::*;
#(
  parameter int NUM_CLASSES = 10,
  parameter int LW          = 4,
  parameter int BEATS       = 8,
  parameter int BW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [LW-1:0] tl_in,
  input  logic [LW-1:0] pl_in,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] beat,
  output hdc_op_e       op,
  output logic [LW-1:0] tl,
  output logic [LW-1:0] pl
);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [BW-1:0] beat_q, beat_d;
  hdc_op_e       op_q, op_d;
  logic [LW-1:0] tl_q, tl_d, pl_q, pl_d;
  logic          tl_ok, pl_ok, legal;

  always_comb begin
    tl_ok = 32'(tl_in) < NUM_CLASSES;
    pl_ok = 32'(pl_in) < NUM_CLASSES;
    case (cmd_op)
      OP_TRAIN:    legal = tl_ok;
      OP_RETRAIN:  legal = tl_ok && pl_ok && (tl_in != pl_in);
      OP_BINARIZE: legal = 1'b1;
      default:     legal = 1'b0;
    endcase
    accept = cmd_valid && !busy_q && legal;
  end

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    done_d = 1'b0;
    op_d   = op_q;
    tl_d   = tl_q;
    pl_d   = pl_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
      op_d   = hdc_op_e'(cmd_op);
      tl_d   = tl_in;
      pl_d   = pl_in;
    end else if (busy_q) begin
      if (beat_q == BW'(BEATS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      beat_q <= '0;
      op_q   <= OP_NONE;
      tl_q   <= '0;
      pl_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      beat_q <= beat_d;
      op_q   <= op_d;
      tl_q   <= tl_d;
      pl_q   <= pl_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign beat = beat_q;
  assign op   = op_q;
  assign tl   = tl_q;
  assign pl   = pl_q;

endmodule

// File: rtl/hdc_sat_lane.sv
module hdc_sat_lane #(
  parameter int ACC_W = 12
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             en,
  input  logic             up,
  output logic [ACC_W-1:0] nxt
);

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  always_comb begin
    if (!en) begin
      nxt = acc;
    end else if (up) begin
      nxt = (acc == ACC_MAX) ? acc : acc + ACC_W'(1);
    end else begin
      nxt = (acc == ACC_MIN) ? acc : acc - ACC_W'(1);
    end
  end

endmodule

// File: rtl/hdc_acc_bank.sv
module hdc_acc_bank #(
  parameter int NUM_CLASSES = 10,
  parameter int LANES       = 32,
  parameter int BEATS       = 8,
  parameter int BW          = 3,
  parameter int ACC_W       = 12,
  parameter int LW          = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [BW-1:0]                           beat,
  input  logic [LANES-1:0]                        slice,
  input  logic                                    upd_en,
  input  logic                                    retrain,
  input  logic [LW-1:0]                           tl,
  input  logic [LW-1:0]                           pl,
  output logic [NUM_CLASSES-1:0][LANES-1:0][ACC_W-1:0] acc_lane
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic add_c, sub_c, col_en;

    always_comb begin
      add_c  = upd_en && (tl == LW'(c));
      sub_c  = upd_en && retrain && (pl == LW'(c));
      col_en = add_c || sub_c;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ACC_W-1:0] col_q [BEATS];
      logic [ACC_W-1:0] cur, nxt;
      logic             up;

      assign cur = col_q[beat];
      assign up  = add_c ? slice[i] : !slice[i];

      hdc_sat_lane #(.ACC_W(ACC_W)) u_sat (
        .acc (cur),
        .en  (col_en),
        .up  (up),
        .nxt (nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int b = 0; b < BEATS; b++) col_q[b] <= '0;
        end else if (col_en) begin
          col_q[beat] <= nxt;
        end
      end

      assign acc_lane[c][i] = cur;
    end
  end

endmodule

// File: rtl/hdc_bin_store.sv
module hdc_bin_store #(
  parameter int NUM_CLASSES = 10,
  parameter int LANES       = 32,
  parameter int BEATS       = 8,
  parameter int BW          = 3,
  parameter int ACC_W       = 12
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         bin_en,
  input  logic [BW-1:0]                                beat,
  input  logic [NUM_CLASSES-1:0][LANES-1:0][ACC_W-1:0] acc_lane,
  output logic [NUM_CLASSES-1:0][BEATS-1:0][LANES-1:0] proto
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic [BEATS-1:0][LANES-1:0] row_q;
    logic [LANES-1:0]            bits_d;

    always_comb begin
      for (int i = 0; i < LANES; i++) begin
        bits_d[i] = !acc_lane[c][i][ACC_W-1] && (acc_lane[c][i] != '0);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (bin_en) begin
        row_q[beat] <= bits_d;
      end
    end

    assign proto[c] = row_q;
  end

endmodule

// File: rtl/hdc_proto_trainer.sv
module hdc_proto_trainer
  import hdc_pkg::*;
#(
  parameter int NUM_CLASSES = 10,
  parameter int DIM         = 256,
  parameter int LANES       = 32,
  parameter int ACC_W       = 12,
  localparam int LW         = $clog2(NUM_CLASSES),
  localparam int BEATS      = DIM / LANES,
  localparam int BW         = $clog2(BEATS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [DIM-1:0] sample_hv,
  input  logic [LW-1:0]  true_label,
  input  logic [LW-1:0]  pred_label,
  output logic           busy,
  output logic           done,
  input  logic [LW-1:0]  rd_class,
  output logic [DIM-1:0] rd_proto
);

  // DIM must be a multiple of LANES with at least two beats.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          accept;
  logic [BW-1:0] beat;
  hdc_op_e       op;
  logic [LW-1:0] tl, pl;

  hdc_ctrl #(
    .NUM_CLASSES(NUM_CLASSES), .LW(LW), .BEATS(BEATS), .BW(BW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .tl_in     (true_label),
    .pl_in     (pred_label),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .beat      (beat),
    .op        (op),
    .tl        (tl),
    .pl        (pl)
  );

  logic [BEATS-1:0][LANES-1:0] sample_q, sample_d;

  always_comb sample_d = accept ? sample_hv : sample_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sample_q <= '0;
    else             sample_q <= sample_d;
  end

  logic upd_en, is_retrain, bin_en;

  always_comb begin
    upd_en     = busy && (op == OP_TRAIN || op == OP_RETRAIN);
    is_retrain = (op == OP_RETRAIN);
    bin_en     = busy && (op == OP_BINARIZE);
  end

  logic [NUM_CLASSES-1:0][LANES-1:0][ACC_W-1:0] acc_lane;
  logic [NUM_CLASSES-1:0][BEATS-1:0][LANES-1:0] proto;

  hdc_acc_bank #(
    .NUM_CLASSES(NUM_CLASSES), .LANES(LANES), .BEATS(BEATS),
    .BW(BW), .ACC_W(ACC_W), .LW(LW)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .beat     (beat),
    .slice    (sample_q[beat]),
    .upd_en   (upd_en),
    .retrain  (is_retrain),
    .tl       (tl),
    .pl       (pl),
    .acc_lane (acc_lane)
  );

  hdc_bin_store #(
    .NUM_CLASSES(NUM_CLASSES), .LANES(LANES), .BEATS(BEATS),
    .BW(BW), .ACC_W(ACC_W)
  ) u_bin (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bin_en   (bin_en),
    .beat     (beat),
    .acc_lane (acc_lane),
    .proto    (proto)
  );

  always_comb begin
    if (32'(rd_class) < NUM_CLASSES) rd_proto = proto[rd_class];
    else                             rd_proto = '0;
  end

endmodule

// File: rtl/hdc_proto_trainer_chk.sv
module hdc_proto_trainer_chk #(
  parameter int NUM_CLASSES = 10,
  parameter int DIM         = 256,
  parameter int LANES       = 32,
  parameter int LW          = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic [1:0]     cmd_op,
  input logic [LW-1:0]  true_label,
  input logic [LW-1:0]  pred_label,
  input logic           busy,
  input logic           done,
  input logic [LW-1:0]  rd_class,
  input logic [DIM-1:0] rd_proto
);

  localparam int BEATS = DIM / LANES;

  logic [15:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R1: outputs idle right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done);

  // R8: busy window length
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == 16'(BEATS));

  // R8: done only as busy falls
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R4: equal labels on retrain never start an update
  a_r4_equal_labels: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 2'b01 && true_label == pred_label |=> !busy);

  // R9: out-of-range label or reserved op never starts an update
  a_r9_bad_label: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && (cmd_op == 2'b11 ||
      (cmd_op != 2'b10 && 32'(true_label) >= NUM_CLASSES)) |=> !busy);

  // R7: prototype read is steady while no command was running
  a_r7_proto_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_class) && !$past(busy) |-> $stable(rd_proto));

endmodule

bind hdc_proto_trainer hdc_proto_trainer_chk #(
  .NUM_CLASSES(NUM_CLASSES), .DIM(DIM), .LANES(LANES), .LW(LW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .true_label (true_label),
  .pred_label (pred_label),
  .busy       (busy),
  .done       (done),
  .rd_class   (rd_class),
  .rd_proto   (rd_proto)
);

// File: tb/hdc_proto_trainer_bench.sv
module hdc_proto_trainer_bench;

  localparam int C     = 3;
  localparam int D     = 32;
  localparam int W     = 8;
  localparam int AW    = 4;
  localparam int LW    = 2;
  localparam int BEATS = D / W;
  localparam int VMAX  = 7;
  localparam int VMIN  = -8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [D-1:0]  sample_hv;
  logic [LW-1:0] true_label, pred_label;
  logic          busy, done;
  logic [LW-1:0] rd_class;
  logic [D-1:0]  rd_proto;

  always #5 clk = ~clk;

  hdc_proto_trainer #(.NUM_CLASSES(C), .DIM(D), .LANES(W), .ACC_W(AW)) u_hdc_proto_trainer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .sample_hv(sample_hv), .true_label(true_label), .pred_label(pred_label),
    .busy(busy), .done(done), .rd_class(rd_class), .rd_proto(rd_proto)
  );

  int total = 0, failed = 0;
  bit finished = 0;
  int model [C][D];
  logic [D-1:0] bin_model [C];

  typedef struct { int cls; logic [D-1:0] exp; string tag; } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  function automatic int clampv(input int v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic logic [D-1:0] proto_of(input int c);
    logic [D-1:0] r;
    for (int d = 0; d < D; d++) r[d] = model[c][d] > 0;
    return r;
  endfunction

  task automatic push_protos(input string tag);
    for (int c = 0; c < C; c++) begin
      item_t it;
      it.cls = c; it.exp = bin_model[c]; it.tag = tag;
      q.push_back(it);
    end
    wait (q.size() == 0);
  endtask

  task automatic apply_model(input logic [1:0] op, input int t, input int p, input logic [D-1:0] hv);
    for (int d = 0; d < D; d++) begin
      int s;
      s = hv[d] ? 1 : -1;
      if (op == 2'b00 || op == 2'b01) model[t][d] = clampv(model[t][d] + s);
      if (op == 2'b01) model[p][d] = clampv(model[p][d] - s);
    end
    if (op == 2'b10) for (int c = 0; c < C; c++) bin_model[c] = proto_of(c);
  endtask

  task automatic wait_finish(input string tag);
    int cycles;
    cycles = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) cycles++;
    end
    chk(cycles == BEATS, {tag, " R8 busy length"}, 64'(cycles), 64'(BEATS));
    chk(done == 1'b1, {tag, " R8 done pulse"}, 64'(done), 64'd1);
  endtask

  task automatic do_cmd(input logic [1:0] op, input int t, input int p,
                        input logic [D-1:0] hv, input bit exp_acc, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; true_label = LW'(t); pred_label = LW'(p); sample_hv = hv;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == exp_acc, {tag, " accept"}, 64'(busy), 64'(exp_acc));
    if (exp_acc && busy) begin
      wait_finish(tag);
      apply_model(op, t, p, hv);
      if (op == 2'b10) push_protos(tag);
    end
  endtask

  initial begin
    @(negedge clk);
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && !busy) begin
        item_t it;
        it = q.pop_front();
        rd_class = LW'(it.cls);
        #1;
        chk(rd_proto == it.exp, it.tag, 64'(rd_proto), 64'(it.exp));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [D-1:0] hva, hvb, hvc, hvs;
    item_t it;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b11; sample_hv = '0;
    true_label = '0; pred_label = '0; rd_class = '0;
    for (int c = 0; c < C; c++) begin
      bin_model[c] = '0;
      for (int d = 0; d < D; d++) model[c][d] = 0;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle in reset", {busy, done}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 64'd0);
    push_protos("R1 prototypes zero");

    hva = 32'hA5C3_0F71; hvb = 32'h1234_ABCD; hvc = 32'hF0F0_5A5A; hvs = 32'h0000_FFFF;

    do_cmd(2'b00, 0, 0, hva, 1, "R2 train class0");
    do_cmd(2'b10, 0, 0, '0, 1, "R6 R2 binarize after train");

    do_cmd(2'b00, 1, 0, hvb, 1, "R2 train class1");
    push_protos("R7 unchanged before binarize");
    do_cmd(2'b10, 0, 0, '0, 1, "R6 binarize class1");

    do_cmd(2'b00, 1, 0, ~hvb, 1, "R6 cancel class1");
    do_cmd(2'b10, 0, 0, '0, 1, "R6 zero maps to 0");

    do_cmd(2'b01, 2, 0, hvc, 1, "R3 retrain 2 over 0");
    push_protos("R7 unchanged after retrain");
    do_cmd(2'b10, 0, 0, '0, 1, "R3 binarize after retrain");

    do_cmd(2'b01, 1, 1, hvc, 0, "R4 equal labels");
    do_cmd(2'b00, 3, 0, hvc, 0, "R9 label out of range");
    do_cmd(2'b01, 0, 3, hvc, 0, "R9 pred out of range");
    do_cmd(2'b11, 0, 1, hvc, 0, "R9 reserved op");
    do_cmd(2'b10, 0, 0, '0, 1, "R4 R9 no update");

    // R8: second command offered mid-update is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; true_label = 2'd1; sample_hv = hva;
    @(negedge clk);
    chk(busy == 1'b1, "R8 first accepted", 64'(busy), 64'd1);
    cmd_op = 2'b00; true_label = 2'd2; sample_hv = ~hva;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    apply_model(2'b00, 1, 0, hva);
    @(negedge clk);
    chk(busy == 1'b0, "R8 second ignored", 64'(busy), 64'd0);
    do_cmd(2'b10, 0, 0, '0, 1, "R8 overlap binarize");

    for (int k = 0; k < 12; k++) do_cmd(2'b00, 2, 0, hvs, 1, "R5 drive to clamp");
    for (int k = 0; k < 8; k++) do_cmd(2'b00, 2, 0, ~hvs, 1, "R5 back off");
    do_cmd(2'b10, 0, 0, '0, 1, "R5 clamp binarize");
    for (int k = 0; k < 9; k++) do_cmd(2'b00, 2, 0, hvs, 1, "R5 recover");
    do_cmd(2'b10, 0, 0, '0, 1, "R5 floor binarize");

    it.cls = 3; it.exp = '0; it.tag = "R10 out-of-range read";
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
    summary();
  end

endmodule